// File: doc/BRIEF.md
# Edge-latched nonvolatile RAM front end

This block is the control logic of a bytewide nonvolatile RAM with an asynchronous parallel interface. The memory pins are active-low: chip select `ce_n`, write strobe `we_n` and output enable `oe_n`. Along with the address and write data, they pass through two-flop synchronizers clocked by a fast system clock. A falling edge on the chip select starts every memory cycle. That edge captures the address, and the state of the write strobe at that moment decides whether the cycle begins as a write or as a read. A read cycle becomes a write if the write strobe falls later in the same cycle. The write completes on whichever strobe rises first, and the array stores the bus value present at that moment.

The block counts the access window and the precharge window in whole clock periods, always rounding up. Read data goes out only when three things hold: the output enable is low, the access window has elapsed, and no write is under way. Rather than a tristate pin, the bus is split into `dq_in`, `dq_out` and a drive enable `dq_oe`. Three sticky flags report interface timing errors: a chip-select low time that is too short, a precharge that is too short, and write data that changed inside the setup window. The flags clear only on reset.

Top module: `nvr_edge_ctrl`

## Requirements
- R1: After reset, `dq_oe` is 0 and `viol` is 3'b000.
- R2: The address is captured only on a falling edge of `ce_n`. Changes to `addr` while `ce_n` stays low have no effect on which byte the cycle reads or writes.
- R3: In a read cycle with `oe_n` held low, `dq_oe` rises on the (ACC_CYC+3)-th rising clock edge after `ce_n` is driven low, and not earlier. This count is 2 synchronizer stages, 1 edge-detect edge and ACC_CYC = ceil(T_ACC_NS/CLK_NS). Once `dq_oe` is up, `dq_out` carries the byte at the captured address.
- R4: While `oe_n` is high, `dq_oe` stays 0. When `oe_n` falls after the access window has already elapsed, the bus is driven two clock edges later.
- R5: If `we_n` is low when the `ce_n` falling edge is seen, the cycle is a write from the start, and `dq_oe` stays 0 for the whole cycle whatever `oe_n` does.
- R6: If `we_n` falls during a read cycle, `dq_oe` drops 2 clock edges after the `we_n` change, and the cycle becomes a write.
- R7: A write completes on the first rise of `we_n` or `ce_n` and stores the `dq_in` value present at that moment. A `we_n` rise that follows a `ce_n` rise writes nothing. `dq_oe` is 0 on the cycle a write is committed.
- R8: After `we_n` rises and ends a write, with `ce_n` still low, `dq_oe` stays 0 for WX_CYC = ceil(T_WX_NS/CLK_NS) cycles beyond the commit. It then drives the newly written byte.
- R9: `viol[0]` is set when `ce_n` is high again within ACC_CYC clock periods of falling. A write in such a cycle is still stored.
- R10: `viol[1]` is set when `ce_n` falls again less than PC_CYC = ceil(T_PC_NS/CLK_NS) clock periods after rising. The new cycle still proceeds.
- R11: `viol[2]` is set when a write is committed less than SU_CYC = ceil(T_SU_NS/CLK_NS) clock periods after `dq_in` last changed.
- R12: Once set, a bit of `viol` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every window is counted in its periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low; its falling edge starts a cycle |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address, captured at the chip-select falling edge |
| dq_in | input | DATA_W | Data arriving on the bus |
| dq_out | output | DATA_W | Read data (0 when not driven, with ZERO_IDLE=1) |
| dq_oe | output | 1 | High while the block drives the bus |
| viol | output | 3 | Sticky flags: bit 0 short chip-select, bit 1 short precharge, bit 2 setup |

## Verification
The bench builds the block with ADDR_W=10 and CLK_NS=20. That gives an access window of 4 cycles, a precharge of 3, a setup window of 2 and a redrive gap of 1. Counts this small let directed tests place a chip-select edge, a strobe edge or a data change exactly one cycle inside or outside each window, so every boundary is hit precisely. The reduced array keeps the run short, and it still exercises the address latch, read-to-write conversion and commit on either strobe.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

   typedef enum logic [1:0] {
      NVR_IDLE   = 2'd0,
      NVR_ACTIVE = 2'd1,
      NVR_PRECH  = 2'd2
   } nvr_state_e;

   localparam int NVR_V_CE_SHORT = 0;
   localparam int NVR_V_PC_SHORT = 1;
   localparam int NVR_V_SETUP    = 2;
   localparam int NVR_V_W        = 3;

   function automatic int nvr_cycles(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/nvr_sync.sv
module nvr_sync #(
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= RST_VAL[i];
            s2 <= RST_VAL[i];
         end else begin
            s1 <= d[i];
            s2 <= s1;
         end
      end
      assign q[i] = s2;
   end
endmodule

// File: rtl/nvr_store.sv
module nvr_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/nvr_cycle_ctrl.sv
module nvr_cycle_ctrl
   import nvr_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter int ACC_CYC = 7,
   parameter int PC_CYC  = 6,
   parameter int SU_CYC  = 3,
   parameter int WX_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              oe_s,
   input  logic [ADDR_W-1:0] a_s,
   input  logic [DATA_W-1:0] d_s,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              wr_en,
   output logic              bus_en,
   output logic [NVR_V_W-1:0] viol
);
   localparam int AC_W = $clog2(ACC_CYC + 1);
   localparam int PC_W = $clog2(PC_CYC + 1);
   localparam int SU_W = $clog2(SU_CYC + 1);
   localparam int WX_W = $clog2(WX_CYC + 1);
   localparam logic [AC_W-1:0] ACC_LIM  = AC_W'(ACC_CYC);
   localparam logic [AC_W-1:0] ACC_RISE = AC_W'(ACC_CYC - 1);
   localparam logic [PC_W-1:0] PC_LAST  = PC_W'(PC_CYC - 1);
   localparam logic [SU_W-1:0] SU_LIM   = SU_W'(SU_CYC);
   localparam logic [SU_W-1:0] SU_OK    = SU_W'(SU_CYC - 1);
   localparam logic [WX_W-1:0] WX_LIM   = WX_W'(WX_CYC);

   nvr_state_e        state;
   logic              ce_q, we_q;
   logic [DATA_W-1:0] d_q;
   logic [AC_W-1:0]   acc_cnt;
   logic [PC_W-1:0]   pc_cnt;
   logic [SU_W-1:0]   ds_cnt;
   logic [WX_W-1:0]   wx_cnt;
   logic              wr_mode, ce_wr;
   logic [NVR_V_W-1:0] viol_q;

   logic ce_fall, ce_rise, we_fall, we_rise, active;
   logic ce_short, pc_short, su_bad;

   assign ce_fall = ce_q & ~ce_s;
   assign ce_rise = ~ce_q & ce_s;
   assign we_fall = we_q & ~we_s;
   assign we_rise = ~we_q & we_s;
   assign active  = (state == NVR_ACTIVE);

   assign wr_en    = active & wr_mode & (we_rise | ce_rise);
   assign ce_short = active & ce_rise & (acc_cnt < ACC_RISE);
   assign pc_short = (state == NVR_PRECH) & ce_fall & (pc_cnt < PC_LAST);
   assign su_bad   = wr_en & ~((d_s == d_q) & (ds_cnt >= SU_OK));

   assign bus_en = active & ~ce_wr & ~wr_mode & ~ce_s & we_s & ~oe_s &
                   (acc_cnt == ACC_LIM) & (wx_cnt == WX_LIM);
   assign viol   = viol_q;

   // edge history, data stability and write-recovery counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b1;
         we_q   <= 1'b1;
         d_q    <= '0;
         ds_cnt <= SU_LIM;
         wx_cnt <= WX_LIM;
         viol_q <= '0;
      end else begin
         ce_q <= ce_s;
         we_q <= we_s;
         d_q  <= d_s;
         if (d_s != d_q)          ds_cnt <= '0;
         else if (ds_cnt != SU_LIM) ds_cnt <= ds_cnt + 1'b1;
         if (we_rise)             wx_cnt <= '0;
         else if (wx_cnt != WX_LIM) wx_cnt <= wx_cnt + 1'b1;
         viol_q <= viol_q | {su_bad, pc_short, ce_short};
      end
   end

   // memory cycle sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= NVR_IDLE;
         acc_cnt  <= '0;
         pc_cnt   <= PC_LAST;
         wr_mode  <= 1'b0;
         ce_wr    <= 1'b0;
         lat_addr <= '0;
      end else begin
         case (state)
            NVR_IDLE, NVR_PRECH: begin
               if (state == NVR_PRECH) begin
                  if (pc_cnt == PC_LAST) state  <= NVR_IDLE;
                  else                   pc_cnt <= pc_cnt + 1'b1;
               end
               if (ce_fall) begin
                  state    <= NVR_ACTIVE;
                  lat_addr <= a_s;
                  wr_mode  <= ~we_s;
                  ce_wr    <= ~we_s;
                  acc_cnt  <= '0;
               end
            end
            NVR_ACTIVE: begin
               if (acc_cnt != ACC_LIM) acc_cnt <= acc_cnt + 1'b1;
               if (wr_en)        wr_mode <= 1'b0;
               else if (we_fall) wr_mode <= 1'b1;
               if (ce_rise) begin
                  state  <= NVR_PRECH;
                  pc_cnt <= '0;
               end
            end
            default: state <= NVR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nvr_edge_ctrl.sv
module nvr_edge_ctrl
   import nvr_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_ACC_NS  = 70,
   parameter int T_PC_NS   = 60,
   parameter int T_SU_NS   = 30,
   parameter int T_WX_NS   = 10,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [NVR_V_W-1:0] viol
);
   localparam int ACC_CYC = nvr_cycles(T_ACC_NS, CLK_NS);
   localparam int PC_CYC  = nvr_cycles(T_PC_NS, CLK_NS);
   localparam int SU_CYC  = nvr_cycles(T_SU_NS, CLK_NS);
   localparam int WX_CYC  = nvr_cycles(T_WX_NS, CLK_NS);
   localparam int BUS_W   = ADDR_W + DATA_W;

   if (CLK_NS < 1 || CLK_NS > 20) begin : g_bad_clk
      $error("nvr_edge_ctrl: CLK_NS must lie in 1..20");
   end
   if (ADDR_W < 1 || ADDR_W > 13) begin : g_bad_addr
      $error("nvr_edge_ctrl: ADDR_W must lie in 1..13");
   end
   if (ACC_CYC < 2 || PC_CYC < 2 || SU_CYC < 2 || WX_CYC < 1) begin : g_bad_win
      $error("nvr_edge_ctrl: timing windows too short for this clock");
   end

   logic [2:0]        ctl_s;
   logic [BUS_W-1:0]  ad_s;
   logic [ADDR_W-1:0] lat_addr;
   logic              wr_en;
   logic [DATA_W-1:0] rdata;

   nvr_sync #(.W(3), .RST_VAL(3'b111)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s));

   nvr_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(ad_s));

   nvr_cycle_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC),
      .PC_CYC(PC_CYC), .SU_CYC(SU_CYC), .WX_CYC(WX_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ce_s(ctl_s[2]), .we_s(ctl_s[1]), .oe_s(ctl_s[0]),
      .a_s(ad_s[BUS_W-1:DATA_W]), .d_s(ad_s[DATA_W-1:0]),
      .lat_addr(lat_addr), .wr_en(wr_en), .bus_en(dq_oe), .viol(viol));

   nvr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .wr(wr_en), .waddr(lat_addr), .wdata(ad_s[DATA_W-1:0]),
      .raddr(lat_addr), .rdata(rdata));

   if (ZERO_IDLE) begin : g_zero
      assign dq_out = dq_oe ? rdata : '0;
   end else begin : g_hold
      assign dq_out = rdata;
   end
endmodule

// File: rtl/nvr_edge_chk.sv
module nvr_edge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       we_n,
   input logic       oe_n,
   input logic       dq_oe,
   input logic       wr_en,
   input logic [2:0] viol
);
   // R3
   bus_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> ($past(ce_n, 2) == 1'b0));

   // R4
   bus_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> ($past(oe_n, 2) == 1'b0));

   // R6
   bus_off_on_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> ($past(we_n, 2) == 1'b1));

   // R7
   commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !dq_oe);

   // R12
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol != 3'b000) |=> ((viol & $past(viol)) == $past(viol)));
endmodule

bind nvr_edge_ctrl nvr_edge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
   .dq_oe(dq_oe), .wr_en(wr_en), .viol(viol));

// File: tb/tb_nvr_edge_ctrl.sv
module tb_nvr_edge_ctrl;
   localparam int AW = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic [2:0]    viol;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   nvr_edge_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(20)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      chk("R1 dq_oe after reset", dq_oe, 0);
      chk("R1 viol after reset", viol, 0);
   endtask

   // write from start; ended by CE rise while WE is still low
   task automatic t_ce_write();
      oe_n = 1'b0; we_n = 1'b0; addr = 10'd5; dq_in = 8'hA5;
      tick(1);
      ce_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         tick(1);
         chk("R5 no drive in write-from-start cycle", dq_oe, 0);
      end
      ce_n = 1'b1;
      tick(1);
      dq_in = 8'hFF;
      tick(2);
      we_n = 1'b1;
      tick(4);
   endtask

   // read with address change mid-cycle and access-time boundary
   task automatic t_read_bound();
      oe_n = 1'b0; we_n = 1'b1; addr = 10'd5;
      ce_n = 1'b0;
      tick(1);
      addr = 10'd7;
      tick(5);
      chk("R3 bus held off before access window", dq_oe, 0);
      tick(1);
      chk("R3 bus driven at access window", dq_oe, 1);
      chk("R2 R7 byte of latched address, CE-end data", dq_out, 8'hA5);
      ce_n = 1'b1;
      tick(5);
   endtask

   task automatic t_oe_late();
      oe_n = 1'b1; addr = 10'd5;
      ce_n = 1'b0;
      tick(8);
      chk("R4 no drive while OE high", dq_oe, 0);
      oe_n = 1'b0;
      tick(2);
      chk("R4 drive two edges after late OE", dq_oe, 1);
      chk("R4 data after late OE", dq_out, 8'hA5);
      ce_n = 1'b1;
      tick(5);
   endtask

   task automatic t_read_to_write();
      oe_n = 1'b0; we_n = 1'b1; addr = 10'd9; dq_in = 8'h3C;
      ce_n = 1'b0;
      tick(7);
      chk("R6 read phase drives bus", dq_oe, 1);
      we_n = 1'b0;
      tick(1);
      chk("R6 bus still driven one edge after WE low", dq_oe, 1);
      tick(1);
      chk("R6 bus released two edges after WE low", dq_oe, 0);
      tick(3);
      we_n = 1'b1;
      tick(3);
      chk("R8 bus quiet on commit cycle", dq_oe, 0);
      tick(1);
      chk("R8 bus redriven after gap", dq_oe, 1);
      chk("R8 R6 new byte read back", dq_out, 8'h3C);
      ce_n = 1'b1;
      tick(5);
      chk("R6 no violation so far", viol, 0);
   endtask

   task automatic t_short_prech();
      ce_n = 1'b0;
      tick(6);
      ce_n = 1'b1;
      tick(2);
      ce_n = 1'b0;
      tick(6);
      chk("R10 short precharge flagged", viol, 3'b010);
      ce_n = 1'b1;
      tick(5);
   endtask

   task automatic t_short_ce();
      we_n = 1'b0; addr = 10'd12; dq_in = 8'h77;
      ce_n = 1'b0;
      tick(2);
      ce_n = 1'b1;
      tick(1);
      we_n = 1'b1;
      tick(6);
      chk("R9 R12 short chip-select flagged, earlier flag kept", viol, 3'b011);
      oe_n = 1'b0; addr = 10'd12;
      ce_n = 1'b0;
      tick(7);
      chk("R9 write of short cycle stored", dq_out, 8'h77);
      ce_n = 1'b1;
      tick(5);
   endtask

   task automatic t_setup();
      oe_n = 1'b1; we_n = 1'b1; addr = 10'd20; dq_in = 8'h00;
      ce_n = 1'b0;
      tick(5);
      we_n = 1'b0;
      tick(4);
      dq_in = 8'h11;
      tick(1);
      we_n = 1'b1;
      tick(4);
      chk("R11 setup violation flagged", viol, 3'b111);
      ce_n = 1'b1;
      tick(5);
      oe_n = 1'b0; addr = 10'd5;
      ce_n = 1'b0;
      tick(7);
      chk("R12 flags stay after clean cycle", viol, 3'b111);
      chk("R2 clean read still correct", dq_out, 8'hA5);
      ce_n = 1'b1;
      tick(5);
   endtask

   initial begin
      t_reset();
      t_ce_write();
      t_read_bound();
      t_oe_late();
      t_read_to_write();
      t_short_prech();
      t_short_ce();
      t_setup();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule